// File: doc/BRIEF.md
# NAND Flash Command Queue Sequencer

This block sits between a host and an 8-bit asynchronous NAND flash bus that serves up to four chips. The host pushes 32-bit command words into a 16-entry queue. The sequencer takes them in order and runs each one as a short micro-sequence on the flash pins. A word can latch a command byte, latch an address byte, write one data byte, read a run of data bytes, hold the chip enables for a programmed delay, or wait for the selected chips to report ready within a timeout. Bus cycle length and strobe width come from a small configuration register, so slow parts and fast parts can share the same command stream.

The host watches a status word. It gives the number of commands still outstanding, a sticky ready/busy timeout flag and the synchronized levels of the four ready/busy pins. The last byte captured by a read command is held on a separate output. Software uses the outstanding count to find out when the queue has drained, for example before it issues a delay that must not overlap earlier traffic. For that reason the count includes the command that is currently executing.

Top module: `nand_cmdq_seq`

## Requirements
- R1: After reset the status count and timeout flag are 0, all chip enables are high, CLE and ALE are low, both strobes are high and the data bus is not driven.
- R2: Status bits 26:22 give the queued entries plus 1 while a command is executing (at most 17). A command write that arrives while the 16-entry queue is full is dropped and does not change the count.
- R3: Word bits 17:14 select the operation: 0x5 latches a command byte (CLE high), 0x6 latches an address byte (ALE high) and 0x4 writes a data byte. Bits 7:0 are driven on the data bus with output enable high, and the chip-enable outputs carry word bits 13:10 (active low: 0xE chip 0, 0xD chip 1, 0xB chip 2, 0x7 chip 3, 0xF none) for the whole cycle.
- R4: Configuration bits 4:0 (C, reset 4) and bits 9:5 (S, reset 2) set the timing. A latch or data cycle lasts C+1 clocks. Its strobe is low for the first S of those clocks. CLE and ALE hold their level for all C+1 clocks.
- R5: Operation 0x8 reads the number of bytes given in bits 9:0. Each byte takes C+1 clocks with read enable low for the first S clocks, and the byte on the data input at the last clock is stored on the read-byte output. A count of 0 completes in one clock.
- R6: Operations 0xC (idle) and 0x0 (standby) hold the chip enables at bits 13:10 for max(N,1) clocks, where N is bits 9:0, and assert no strobe.
- R7: A word with bit 20 set and bit 21 clear waits until every chip selected by bits 13:10 reads ready (pin high). If that has not happened after T×64 extra clocks (T in bits 4:0), status bit 27 is set and the queue moves on. The flag stays set until the clear input is pulsed. A wait that selects no chip finishes at once.
- R8: Status bits 31:28 show the ready/busy pins after a two-stage synchronizer, and bits 21:0 read as 0.
- R9: A word with an unknown operation code, or with any of bits 31:22, bit 21 or bits 19:18 set (except a wait word), is consumed in one clock with the bus left idle.
- R10: Whenever the outstanding count is 0, all chip enables and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one bus cycle unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_en | input | 1 | Push a command word into the queue |
| cmd_wr_data | input | 32 | Command word |
| cfg_wr_en | input | 1 | Load the timing configuration |
| cfg_wr_data | input | 10 | Bits 4:0 cycle length C, bits 9:5 strobe width S |
| tmo_clr | input | 1 | Clear the sticky timeout flag |
| status | output | 32 | Pins 31:28, timeout 27, outstanding count 26:22 |
| rd_byte | output | 8 | Last byte captured by a read command |
| nand_ce_n | output | 4 | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rb | input | 4 | Ready/busy pins, high means ready |

## Verification
Latch commands are sent under the reset timing and again under a longer cycle with a wider strobe. The strobe-low count and the CLE/ALE high count then show that both configuration fields are honoured, and not just some fixed cycle. The ready/busy wait is run with an unselected chip busy, with a selected chip busy until the limit, with a zero timeout, and with ready arriving partway through. Together these separate the chip masking, the timeout length, the flag and the early exit. A full-queue burst behind a long delay, and words with unknown or reserved bits, check the count and the drop and discard paths.

// File: rtl/nfq_pkg.sv
package nfq_pkg;

  localparam int WORD_W    = 32;
  localparam int NCHIP     = 4;
  localparam int BYTE_W    = 8;
  localparam int LEN_W     = 10;
  localparam int TMO_FLD_W = 5;
  localparam int TIM_W     = 5;

  localparam logic [3:0] OPC_STBY = 4'h0;
  localparam logic [3:0] OPC_DWR  = 4'h4;
  localparam logic [3:0] OPC_CLE  = 4'h5;
  localparam logic [3:0] OPC_ALE  = 4'h6;
  localparam logic [3:0] OPC_DRD  = 4'h8;
  localparam logic [3:0] OPC_IDLE = 4'hC;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_LATCH = 3'd1,
    K_READ  = 3'd2,
    K_DELAY = 3'd3,
    K_WAIT  = 3'd4
  } nfq_kind_e;

  typedef struct packed {
    nfq_kind_e              kind;
    logic [NCHIP-1:0]       ce_n;
    logic                   cle;
    logic                   ale;
    logic [BYTE_W-1:0]      bval;
    logic [LEN_W-1:0]       len;
    logic [TMO_FLD_W-1:0]   tmo;
  } nfq_cmd_t;

endpackage

// File: rtl/nfq_fifo.sv
module nfq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] rptr_q, rptr_d;
  logic [CW-1:0] lvl_q,  lvl_d;
  logic          do_push, do_pop;

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem_q[rptr_q];
  assign level   = lvl_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    if (do_push) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   lvl_d = lvl_q + 1'b1;
      2'b01:   lvl_d = lvl_q - 1'b1;
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  // storage carries no reset; written under its own enable
  always_ff @(posedge clk) begin
    if (do_push) mem_q[wptr_q] <= wdata;
  end

endmodule

// File: rtl/nfq_sync.sv
module nfq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '1;
    else        stg_q[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= '1;
      else        stg_q[g] <= stg_q[g-1];
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/nfq_decode.sv
module nfq_decode
  import nfq_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output nfq_cmd_t          cmd
);

  logic [3:0] opc;
  logic       rsvd_set;

  assign opc      = word[17:14];
  assign rsvd_set = (|word[31:22]) || word[21];

  always_comb begin
    cmd      = '0;
    cmd.kind = K_NONE;
    cmd.ce_n = word[13:10];
    cmd.bval = word[7:0];
    cmd.len  = word[9:0];
    cmd.tmo  = word[4:0];
    if (rsvd_set) begin
      cmd.kind = K_NONE;
    end else if (word[20]) begin
      cmd.kind = K_WAIT;
    end else if (|word[19:18]) begin
      cmd.kind = K_NONE;
    end else begin
      case (opc)
        OPC_CLE:  begin cmd.kind = K_LATCH; cmd.cle = 1'b1; end
        OPC_ALE:  begin cmd.kind = K_LATCH; cmd.ale = 1'b1; end
        OPC_DWR:  cmd.kind = K_LATCH;
        OPC_DRD:  cmd.kind = K_READ;
        OPC_IDLE: cmd.kind = K_DELAY;
        OPC_STBY: cmd.kind = K_DELAY;
        default:  cmd.kind = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/nfq_exec.sv
module nfq_exec
  import nfq_pkg::*;
#(
  parameter int TMO_PRESCALE = 64,
  localparam int PRE_SH      = $clog2(TMO_PRESCALE),
  localparam int TMO_W       = TMO_FLD_W + PRE_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  nfq_cmd_t          cmd,
  input  logic [TIM_W-1:0]  cyc_len,
  input  logic [TIM_W-1:0]  stb_len,
  input  logic [NCHIP-1:0]  rb_sync,
  input  logic [BYTE_W-1:0] dq_in,
  input  logic              tmo_clr,
  output logic              busy,
  output logic              tmo_flag,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [NCHIP-1:0]  ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [BYTE_W-1:0] dq_out,
  output logic              dq_oe
);

  logic              busy_q,  busy_d;
  nfq_cmd_t          cmd_q,   cmd_d;
  logic [TIM_W-1:0]  phase_q, phase_d;
  logic [LEN_W-1:0]  left_q,  left_d;
  logic [TMO_W-1:0]  tcnt_q,  tcnt_d;
  logic              flag_q,  flag_d;
  logic [BYTE_W-1:0] rdb_q,   rdb_d;

  logic              cyc_end;
  logic              rdy;
  logic [TMO_W-1:0]  tlimit;
  logic              on_bus;
  logic              strobe;

  assign cyc_end = (phase_q == cyc_len);
  assign rdy     = &(rb_sync | cmd_q.ce_n);
  assign tlimit  = TMO_W'(cmd_q.tmo) << PRE_SH;

  always_comb begin
    busy_d  = busy_q;
    cmd_d   = cmd_q;
    phase_d = phase_q;
    left_d  = left_q;
    tcnt_d  = tcnt_q;
    flag_d  = flag_q;
    rdb_d   = rdb_q;
    if (tmo_clr) flag_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d  = 1'b1;
        cmd_d   = cmd;
        phase_d = '0;
        left_d  = cmd.len;
        tcnt_d  = '0;
      end
    end else begin
      case (cmd_q.kind)
        K_LATCH: begin
          if (cyc_end) busy_d = 1'b0;
          else         phase_d = phase_q + 1'b1;
        end
        K_READ: begin
          if (left_q == '0) begin
            busy_d = 1'b0;
          end else if (cyc_end) begin
            rdb_d   = dq_in;
            phase_d = '0;
            left_d  = left_q - 1'b1;
            if (left_q == LEN_W'(1)) busy_d = 1'b0;
          end else begin
            phase_d = phase_q + 1'b1;
          end
        end
        K_DELAY: begin
          if (left_q <= LEN_W'(1)) busy_d = 1'b0;
          else                     left_d = left_q - 1'b1;
        end
        K_WAIT: begin
          if (rdy) begin
            busy_d = 1'b0;
          end else if (tcnt_q == tlimit) begin
            flag_d = 1'b1;
            busy_d = 1'b0;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        default: busy_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cmd_q   <= '0;
      phase_q <= '0;
      left_q  <= '0;
      tcnt_q  <= '0;
      flag_q  <= 1'b0;
      rdb_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      cmd_q   <= cmd_d;
      phase_q <= phase_d;
      left_q  <= left_d;
      tcnt_q  <= tcnt_d;
      flag_q  <= flag_d;
      rdb_q   <= rdb_d;
    end
  end

  assign on_bus = busy_q && ((cmd_q.kind == K_LATCH) ||
                             ((cmd_q.kind == K_READ) && (left_q != '0)));
  assign strobe = on_bus && (phase_q < stb_len);

  assign busy     = busy_q;
  assign tmo_flag = flag_q;
  assign rd_byte  = rdb_q;
  assign ce_n     = (busy_q && (cmd_q.kind != K_NONE)) ? cmd_q.ce_n : '1;
  assign cle      = busy_q && (cmd_q.kind == K_LATCH) && cmd_q.cle;
  assign ale      = busy_q && (cmd_q.kind == K_LATCH) && cmd_q.ale;
  assign we_n     = !(strobe && (cmd_q.kind == K_LATCH));
  assign re_n     = !(strobe && (cmd_q.kind == K_READ));
  assign dq_oe    = busy_q && (cmd_q.kind == K_LATCH);
  assign dq_out   = dq_oe ? cmd_q.bval : '0;

endmodule

// File: rtl/nand_cmdq_seq.sv
module nand_cmdq_seq
  import nfq_pkg::*;
#(
  parameter int FIFO_DEPTH   = 16,
  parameter int TMO_PRESCALE = 64,
  parameter int CYC_RST      = 4,
  parameter int STB_RST      = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr_en,
  input  logic [31:0] cmd_wr_data,
  input  logic        cfg_wr_en,
  input  logic [9:0]  cfg_wr_data,
  input  logic        tmo_clr,
  output logic [31:0] status,
  output logic [7:0]  rd_byte,
  output logic [3:0]  nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_out,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_in,
  input  logic [3:0]  nand_rb
);

  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);
  localparam int OUTS_W = $clog2(FIFO_DEPTH + 2);
  localparam int STAT_W = 5;

  logic [WORD_W-1:0] head_word;
  logic              q_empty, q_full;
  logic [LVL_W-1:0]  q_level;
  logic              ex_busy, ex_start;
  logic              ex_flag;
  nfq_cmd_t          head_cmd;
  logic [NCHIP-1:0]  rb_s;
  logic [TIM_W-1:0]  cyc_q, cyc_d;
  logic [TIM_W-1:0]  stb_q, stb_d;
  logic [OUTS_W-1:0] outstanding;

  assign ex_start = !q_empty && !ex_busy;

  nfq_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) i_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (cmd_wr_en),
    .wdata (cmd_wr_data),
    .pop   (ex_start),
    .rdata (head_word),
    .empty (q_empty),
    .full  (q_full),
    .level (q_level)
  );

  nfq_decode i_dec (
    .word (head_word),
    .cmd  (head_cmd)
  );

  nfq_sync #(.W(NCHIP), .STAGES(SYNC_STAGES)) i_rbsync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (nand_rb),
    .dout  (rb_s)
  );

  always_comb begin
    cyc_d = cyc_q;
    stb_d = stb_q;
    if (cfg_wr_en) begin
      cyc_d = cfg_wr_data[4:0];
      stb_d = cfg_wr_data[9:5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= TIM_W'(CYC_RST);
      stb_q <= TIM_W'(STB_RST);
    end else begin
      cyc_q <= cyc_d;
      stb_q <= stb_d;
    end
  end

  nfq_exec #(.TMO_PRESCALE(TMO_PRESCALE)) i_exec (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ex_start),
    .cmd      (head_cmd),
    .cyc_len  (cyc_q),
    .stb_len  (stb_q),
    .rb_sync  (rb_s),
    .dq_in    (nand_dq_in),
    .tmo_clr  (tmo_clr),
    .busy     (ex_busy),
    .tmo_flag (ex_flag),
    .rd_byte  (rd_byte),
    .ce_n     (nand_ce_n),
    .cle      (nand_cle),
    .ale      (nand_ale),
    .we_n     (nand_we_n),
    .re_n     (nand_re_n),
    .dq_out   (nand_dq_out),
    .dq_oe    (nand_dq_oe)
  );

  assign outstanding = OUTS_W'(q_level) + OUTS_W'(ex_busy);

  always_comb begin
    status        = '0;
    status[31:28] = rb_s;
    status[27]    = ex_flag;
    status[26:22] = STAT_W'(outstanding);
  end

  logic unused_full;
  assign unused_full = q_full;

endmodule

// File: rtl/nfq_checker.sv
module nfq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tmo_clr,
  input logic [31:0] status,
  input logic [3:0]  nand_ce_n,
  input logic        nand_cle,
  input logic        nand_ale,
  input logic        nand_we_n,
  input logic        nand_re_n,
  input logic        nand_dq_oe
);

  logic [4:0] cnt;
  assign cnt = status[26:22];

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 5'd17); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 5'd1) ||
             (cnt + 5'd1 == $past(cnt))); // R2

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R3

  AST_WE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe); // R3

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n)); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[27] && !tmo_clr) |=> status[27]); // R7

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 5'd0) |-> (nand_ce_n == 4'hF && nand_we_n && nand_re_n)); // R10

  AST_STATUS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    status[21:0] == 22'd0); // R8

endmodule

bind nand_cmdq_seq nfq_checker i_nfq_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tmo_clr    (tmo_clr),
  .status     (status),
  .nand_ce_n  (nand_ce_n),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_oe (nand_dq_oe)
);

// File: tb/test_nand_cmdq_seq.sv
module test_nand_cmdq_seq;

  logic        clk;
  logic        rst_n;
  logic        cmd_wr_en;
  logic [31:0] cmd_wr_data;
  logic        cfg_wr_en;
  logic [9:0]  cfg_wr_data;
  logic        tmo_clr;
  logic [31:0] status;
  logic [7:0]  rd_byte;
  logic [3:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic [7:0]  nand_dq_out;
  logic        nand_dq_oe;
  logic [7:0]  nand_dq_in;
  logic [3:0]  nand_rb;

  int checks = 0;
  int errors = 0;

  // measurement results
  int         m_span, m_we, m_re, m_cle, m_ale, m_ce_hit, m_ce_other;
  logic [7:0] m_dq;
  logic       m_oe_bad;

  nand_cmdq_seq i_nand_cmdq_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .tmo_clr(tmo_clr),
    .status(status), .rd_byte(rd_byte), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    cmd_wr_en   = 1'b1;
    cmd_wr_data = w;
    @(negedge clk);
    cmd_wr_en   = 1'b0;
  endtask

  task automatic set_cfg(input int cyc, input int stb);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = {5'(stb), 5'(cyc)};
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  // push one word and watch the bus until the outstanding count is 0
  task automatic run(input logic [31:0] w, input logic [3:0] ce_exp, input int rb_rise_at);
    m_span = 0; m_we = 0; m_re = 0; m_cle = 0; m_ale = 0;
    m_ce_hit = 0; m_ce_other = 0; m_dq = 8'h00; m_oe_bad = 1'b0;
    push(w);
    while (status[26:22] != 5'd0 && m_span < 5000) begin
      m_span++;
      if (m_span == rb_rise_at) nand_rb = 4'hF;
      if (!nand_we_n) begin
        m_we++;
        m_dq = nand_dq_out;
        if (!nand_dq_oe) m_oe_bad = 1'b1;
      end
      if (!nand_re_n) m_re++;
      if (nand_cle) m_cle++;
      if (nand_ale) m_ale++;
      if (nand_ce_n == ce_exp && ce_exp != 4'hF) m_ce_hit++;
      else if (nand_ce_n != 4'hF) m_ce_other++;
      @(negedge clk);
    end
    chk("R10", "bus idle after command", int'({nand_ce_n, nand_we_n, nand_re_n, nand_dq_oe}),
        int'({4'hF, 1'b1, 1'b1, 1'b0}));
  endtask

  function automatic logic [31:0] mk(input logic [3:0] opc, input logic [3:0] ce, input logic [9:0] lo);
    return {14'd0, opc, ce, lo};
  endfunction

  function automatic logic [31:0] mkwait(input logic [3:0] ce, input logic [4:0] t);
    return {11'd0, 1'b1, 6'd0, ce, 5'd0, t};
  endfunction

  task automatic t_reset;
    chk("R1", "count", int'(status[26:22]), 0);
    chk("R1", "timeout flag", int'(status[27]), 0);
    chk("R1", "ce_n", int'(nand_ce_n), 15);
    chk("R1", "cle/ale/we_n/re_n/oe", int'({nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe}),
        int'(5'b00110));
  endtask

  task automatic t_latch_default;
    run(mk(4'h5, 4'hE, 10'h070), 4'hE, -1);
    chk("R4", "cle span clocks", m_span, 6);
    chk("R4", "we_n low clocks", m_we, 2);
    chk("R4", "cle high clocks", m_cle, 5);
    chk("R3", "cle byte", int'(m_dq), 'h70);
    chk("R3", "ce_n chip0 clocks", m_ce_hit, 5);
    chk("R3", "ale during cle", m_ale, 0);
    chk("R3", "oe with we", int'(m_oe_bad), 0);
  endtask

  task automatic t_latch_slow;
    set_cfg(7, 3);
    run(mk(4'h6, 4'hB, 10'h012), 4'hB, -1);
    chk("R4", "ale span clocks", m_span, 9);
    chk("R4", "we_n low clocks slow", m_we, 3);
    chk("R4", "ale high clocks", m_ale, 8);
    chk("R3", "ale byte", int'(m_dq), 'h12);
    chk("R3", "ce_n chip2 clocks", m_ce_hit, 8);
    run(mk(4'h4, 4'h7, 10'h0A5), 4'h7, -1);
    chk("R3", "data write byte", int'(m_dq), 'hA5);
    chk("R3", "no cle/ale on data write", m_cle + m_ale, 0);
    chk("R3", "ce_n chip3 clocks", m_ce_hit, 8);
    set_cfg(4, 2);
  endtask

  task automatic t_read;
    nand_dq_in = 8'h3C;
    run(mk(4'h8, 4'hD, 10'd3), 4'hD, -1);
    chk("R5", "read span clocks", m_span, 16);
    chk("R5", "re_n low clocks", m_re, 6);
    chk("R5", "read byte", int'(rd_byte), 'h3C);
    chk("R5", "no we during read", m_we, 0);
    nand_dq_in = 8'hC3;
    run(mk(4'h8, 4'hD, 10'd0), 4'hD, -1);
    chk("R5", "zero-count read span", m_span, 2);
    chk("R5", "zero-count read keeps byte", int'(rd_byte), 'h3C);
  endtask

  task automatic t_delay;
    run(mk(4'hC, 4'hE, 10'd10), 4'hE, -1);
    chk("R6", "idle span clocks", m_span, 11);
    chk("R6", "ce_n held clocks", m_ce_hit, 10);
    chk("R6", "no strobe in idle", m_we + m_re, 0);
    run(mk(4'h0, 4'hF, 10'd0), 4'hF, -1);
    chk("R6", "zero standby span", m_span, 2);
    run(mk(4'h0, 4'hF, 10'd5), 4'hF, -1);
    chk("R6", "standby span", m_span, 6);
    chk("R6", "standby ce_n high", m_ce_other, 0);
  endtask

  task automatic t_wait;
    nand_rb = 4'hF; idle(4);
    run(mkwait(4'hE, 5'd1), 4'hE, -1);
    chk("R7", "ready wait span", m_span, 2);
    nand_rb = 4'hE; idle(4);
    run(mkwait(4'hD, 5'd1), 4'hD, -1);
    chk("R7", "unselected busy ignored span", m_span, 2);
    chk("R7", "no flag when masked", int'(status[27]), 0);
    run(mkwait(4'hF, 5'd0), 4'hF, -1);
    chk("R7", "no chip selected span", m_span, 2);
    run(mkwait(4'hE, 5'd1), 4'hE, -1);
    chk("R7", "timeout span", m_span, 66);
    chk("R7", "timeout flag set", int'(status[27]), 1);
    run(mkwait(4'hD, 5'd1), 4'hD, -1);
    chk("R7", "flag sticky", int'(status[27]), 1);
    @(negedge clk); tmo_clr = 1'b1; @(negedge clk); tmo_clr = 1'b0;
    chk("R7", "flag cleared", int'(status[27]), 0);
    run(mkwait(4'hE, 5'd0), 4'hE, -1);
    chk("R7", "zero timeout span", m_span, 2);
    chk("R7", "zero timeout flag", int'(status[27]), 1);
    @(negedge clk); tmo_clr = 1'b1; @(negedge clk); tmo_clr = 1'b0;
    run(mkwait(4'hE, 5'd2), 4'hE, 20);
    chk("R7", "early ready flag", int'(status[27]), 0);
    chk("R7", "early ready ended before limit", int'(m_span > 20 && m_span < 30), 1);
  endtask

  task automatic t_status_pins;
    nand_rb = 4'hA; idle(3);
    chk("R8", "rb pins in status", int'(status[31:28]), 'hA);
    chk("R8", "low status bits", int'(status[21:0]), 0);
    nand_rb = 4'hF; idle(3);
    chk("R8", "rb pins all ready", int'(status[31:28]), 'hF);
  endtask

  task automatic t_unknown;
    run(mk(4'h3, 4'hE, 10'h055), 4'hE, -1);
    chk("R9", "unknown opcode span", m_span, 2);
    chk("R9", "unknown opcode bus quiet", m_we + m_re + m_ce_hit + m_ce_other, 0);
    run(32'h0020_0000 | mk(4'h5, 4'hE, 10'h011), 4'hE, -1);
    chk("R9", "bit21 word span", m_span, 2);
    chk("R9", "bit21 word no cle", m_cle + m_we, 0);
    run(32'h0004_0000 | mk(4'h5, 4'hE, 10'h011), 4'hE, -1);
    chk("R9", "bit18 word span", m_span, 2);
    run(32'h8000_0000 | mk(4'hC, 4'hE, 10'd40), 4'hE, -1);
    chk("R9", "high bit word span", m_span, 2);
  endtask

  task automatic t_fifo_full;
    push(mk(4'h0, 4'hF, 10'd200));
    for (int i = 0; i < 16; i++) push(mk(4'h0, 4'hF, 10'd1));
    chk("R2", "count with full queue", int'(status[26:22]), 17);
    push(mk(4'h0, 4'hF, 10'd1));
    chk("R2", "write while full dropped", int'(status[26:22]), 17);
    for (int i = 0; i < 1000 && status[26:22] != 5'd0; i++) @(negedge clk);
    chk("R2", "queue drained", int'(status[26:22]), 0);
  endtask

  initial begin
    rst_n = 1'b0; cmd_wr_en = 1'b0; cmd_wr_data = '0; cfg_wr_en = 1'b0;
    cfg_wr_data = '0; tmo_clr = 1'b0; nand_dq_in = 8'h00; nand_rb = 4'hF;
    idle(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    idle(3);
    t_latch_default();
    t_latch_slow();
    t_read();
    t_delay();
    t_wait();
    t_status_pins();
    t_unknown();
    t_fifo_full();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule